// File: doc/BRIEF.md
# Per-Bit Metastability Coverage Monitor

The monitor runs in the receive clock domain beside a synchronizer whose first stage has a metastability injector on it. For each bit of the crossing register it gets three inputs every cycle. The first is a pulse that marks a cycle where injection was active: the receive edge came close to a source change. The second is the value an ideal first stage would have captured. The third is the value the injected first stage actually holds. From these inputs it keeps four statistics per bit:

- how many cycles were metastable;
- how many transitions arrived one cycle late;
- how many transitions arrived one cycle early;
- a sticky flag showing whether the bit was ever captured inverted.

Software-independent readout goes through a small request/response stream. A request carries a bit index and a statistic code. The response carries the 16-bit value one cycle later. A response that the consumer has not taken blocks further requests: `req_ready` is low while `rsp_valid` is high and `rsp_ready` is low. The response data stays frozen until it is taken. A synchronous clear input zeroes every statistic at once.

Top module: `cdc_meta_cov`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every statistic reads zero, `rsp_valid` is low and `req_ready` is high.
- R2: The metastable-cycle count of bit i rises by one on each clock edge where `inject[i]` is high.
- R3: The delayed-transition count of bit i rises by one on an edge where all of the following hold: `ideal[i]` differs from its value on the previous edge, `actual[i]` does not, and the two now disagree.
- R4: The advanced-transition count of bit i rises by one on an edge where all of the following hold: `actual[i]` differs from its value on the previous edge, `ideal[i]` does not, and the two now disagree. A catch-up edge that brings the two back into agreement counts as neither delayed nor advanced.
- R5: The inverted flag of bit i is set on any edge where `actual[i]` differs from `ideal[i]`. Once set, it stays set until a clear or a reset.
- R6: Each count is 16 bits wide and holds at 65535 instead of wrapping.
- R7: On an edge with `clr` high, all counts and flags become zero. Clear wins over any event on that same edge. The previous-sample history is still updated, so a transition on the edge after a clear is counted against the values seen during the clear.
- R8: The first edge after reset only records history. A difference between the inputs on that edge and the reset state counts as neither a delayed nor an advanced transition.
- R9: Events on one bit change only that bit's statistics.
- R10: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `req_ready` equals `!rsp_valid || rsp_ready`. The response appears with `rsp_valid` on the next cycle and shows the statistic as it stood before the accepting edge. While `rsp_ready` is low, `rsp_valid` and `rsp_data` hold.
- R11: `req_code` selects the statistic: 0 = metastable cycles, 1 = delayed, 2 = advanced, 3 = inverted flag in bit 0 with the upper bits zero. An index at or above the bit count returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics |
| inject | input | N_BITS | Per-bit injection-active pulse |
| ideal | input | N_BITS | Per-bit ideal first-stage capture |
| actual | input | N_BITS | Per-bit injected first-stage value |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request ready |
| req_idx | input | IDX_W | Bit index of the request |
| req_code | input | 2 | Statistic code of the request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | CNT_W | Response value |

## Verification
Saturation is the hardest state to reach from the ports, because a count only hits its ceiling after 65535 qualifying edges. The bench holds the injection pulse of one bit high for slightly more than that many cycles, then reads the count back and also checks that a neighbouring bit did not move. Delayed and advanced events, together with their catch-up edges, come from random stimulus. In that stimulus the actual value follows the ideal one, except where a random injection flips it. Directed cases cover the first edge after reset, clear colliding with events, and a stalled response.

// File: rtl/cdc_cov_pkg.sv
package cdc_cov_pkg;
  typedef enum logic [1:0] {
    STAT_META  = 2'd0,
    STAT_LATE  = 2'd1,
    STAT_EARLY = 2'd2,
    STAT_FLIP  = 2'd3
  } stat_e;
endpackage

// File: rtl/cdc_mon_satcnt.sv
module cdc_mon_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (inc && cnt != MAXV)   cnt <= cnt + 1'b1;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> cnt == MAXV); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R2
endmodule

// File: rtl/cdc_mon_bit.sv
module cdc_mon_bit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         primed,
  input  logic         inj,
  input  logic         ideal,
  input  logic         actual,
  output logic [W-1:0] meta_cnt,
  output logic [W-1:0] late_cnt,
  output logic [W-1:0] early_cnt,
  output logic         flipped
);
  logic ideal_q, actual_q;
  logic ideal_chg, actual_chg, disagree, late_ev, early_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ideal_q  <= 1'b0;
      actual_q <= 1'b0;
    end else begin
      ideal_q  <= ideal;
      actual_q <= actual;
    end
  end

  always_comb begin
    ideal_chg  = primed && (ideal != ideal_q);
    actual_chg = primed && (actual != actual_q);
    disagree   = (ideal != actual);
    late_ev    = ideal_chg && !actual_chg && disagree;
    early_ev   = actual_chg && !ideal_chg && disagree;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) flipped <= 1'b0;
    else if (disagree) flipped <= 1'b1;
  end

  cdc_mon_satcnt #(.W(W)) u_meta  (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(inj),      .cnt(meta_cnt));
  cdc_mon_satcnt #(.W(W)) u_late  (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(late_ev),  .cnt(late_cnt));
  cdc_mon_satcnt #(.W(W)) u_early (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(early_ev), .cnt(early_cnt));

  AST_FLIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flipped && !clr) |=> flipped); // R5
  AST_FIRST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!primed && !clr) |=> (late_cnt == '0 && early_cnt == '0)); // R8
endmodule

// File: rtl/cdc_mon_rdport.sv
module cdc_mon_rdport
  import cdc_cov_pkg::*;
#(
  parameter int N  = 6,
  parameter int W  = 16,
  parameter int IW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0][W-1:0] meta,
  input  logic [N-1:0][W-1:0] late,
  input  logic [N-1:0][W-1:0] early,
  input  logic [N-1:0]        flip,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [IW-1:0]       req_idx,
  input  stat_e               req_code,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [W-1:0]        rsp_data
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (req_idx == IW'(i)) begin
        unique case (req_code)
          STAT_META:  sel = meta[i];
          STAT_LATE:  sel = late[i];
          STAT_EARLY: sel = early[i];
          STAT_FLIP:  sel = W'(flip[i]);
        endcase
      end
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
  AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10
endmodule

// File: rtl/cdc_meta_cov.sv
module cdc_meta_cov
  import cdc_cov_pkg::*;
#(
  parameter int N_BITS = 6,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [N_BITS-1:0] inject,
  input  logic [N_BITS-1:0] ideal,
  input  logic [N_BITS-1:0] actual,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [1:0]        req_code,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CNT_W-1:0]  rsp_data
);
  logic primed;
  logic [N_BITS-1:0][CNT_W-1:0] meta_v, late_v, early_v;
  logic [N_BITS-1:0]            flip_v;

  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  for (genvar b = 0; b < N_BITS; b++) begin : g_bit
    cdc_mon_bit #(.W(CNT_W)) u_bit (
      .clk(clk), .rst_n(rst_n), .clr(clr), .primed(primed),
      .inj(inject[b]), .ideal(ideal[b]), .actual(actual[b]),
      .meta_cnt(meta_v[b]), .late_cnt(late_v[b]), .early_cnt(early_v[b]),
      .flipped(flip_v[b])
    );
  end

  cdc_mon_rdport #(.N(N_BITS), .W(CNT_W), .IW(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .meta(meta_v), .late(late_v), .early(early_v), .flip(flip_v),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .req_code(stat_e'(req_code)),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  AST_PRIMED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed); // R8
endmodule

// File: tb/sim_cdc_meta_cov.sv
module sim_cdc_meta_cov;
  localparam int N = 6;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [N-1:0] inject = '0, ideal = '1, actual = 6'b111110;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [IW-1:0] req_idx = '0;
  logic [1:0] req_code = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_data;

  int checks = 0, failures = 0;
  int m_meta[N], m_late[N], m_early[N];
  bit m_flip[N], p_ideal[N], p_act[N], m_primed;

  always #2 clk = ~clk;

  cdc_meta_cov #(.N_BITS(N), .CNT_W(16), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inject(inject), .ideal(ideal),
    .actual(actual), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_code(req_code), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // independent reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_meta[i] = 0; m_late[i] = 0; m_early[i] = 0; m_flip[i] = 0;
        p_ideal[i] = 0; p_act[i] = 0;
      end
      m_primed = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit ic, ac, dif;
        ic = ideal[i] != p_ideal[i];
        ac = actual[i] != p_act[i];
        dif = ideal[i] != actual[i];
        if (clr) begin
          m_meta[i] = 0; m_late[i] = 0; m_early[i] = 0; m_flip[i] = 0;
        end else begin
          if (inject[i] && m_meta[i] < 65535) m_meta[i]++;
          if (m_primed && ic && !ac && dif && m_late[i] < 65535) m_late[i]++;
          if (m_primed && ac && !ic && dif && m_early[i] < 65535) m_early[i]++;
          if (dif) m_flip[i] = 1;
        end
        p_ideal[i] = ideal[i];
        p_act[i] = actual[i];
      end
      m_primed = 1;
    end
  end

  function automatic int exp_val(int idx, int code);
    if (idx >= N) return 0;
    case (code)
      0: return m_meta[idx];
      1: return m_late[idx];
      2: return m_early[idx];
      default: return int'(m_flip[idx]);
    endcase
  endfunction

  function automatic string req_of(int idx, int code);
    if (idx >= N) return "R11";
    case (code)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] inj, logic [N-1:0] idl, logic [N-1:0] act);
    @(negedge clk);
    inject = inj; ideal = idl; actual = act;
  endtask

  task automatic do_read(int idx, int code, string rq);
    int e;
    @(negedge clk);
    inject = '0;
    e = exp_val(idx, code);
    req_valid = 1'b1; req_idx = IW'(idx); req_code = 2'(code);
    @(negedge clk);
    req_valid = 1'b0;
    check({rq, " rsp_valid"}, int'(rsp_valid), 1);
    check(rq, int'(rsp_data), e);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ci, ca;
    logic [15:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", int'(rsp_valid), 0);
    check("R1 req_ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;        // bit0 disagrees with reset history: R8
    do_read(0, 1, "R8 late after first edge");
    do_read(0, 2, "R8 early after first edge");
    do_read(3, 0, "R1 meta zero");
    do_read(0, 3, "R5 flag set by disagreement");

    // directed delayed then catch-up on bit 2: R3, R4
    step('0, 6'b111111, 6'b111111);
    step('0, 6'b111011, 6'b111111);
    step('0, 6'b111011, 6'b111011);
    do_read(2, 1, "R3 delayed once");
    do_read(2, 2, "R4 catch-up not advanced");

    // random phase
    ci = 6'b111011; ca = ci;
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] inj, fl;
      for (int b = 0; b < N; b++) begin
        if ($urandom % 4 == 0) ci[b] = ~ci[b];
        inj[b] = ($urandom % 5 == 0);
        fl[b] = inj[b] & $urandom % 2;
      end
      ca = ci ^ fl;
      step(inj, ci, ca);
      if (c % 100 == 99) begin
        int ri, rc;
        ri = int'($urandom_range(0, 7)); rc = int'($urandom_range(0, 3));
        do_read(ri, rc, req_of(ri, rc));
      end
    end
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 4; k++) do_read(i, k, req_of(i, k));

    // clear colliding with injections, history kept: R7
    step('0, ci, ci);
    step('0, ci, ci);
    @(negedge clk); clr = 1'b1; inject = '1;
    @(negedge clk); clr = 1'b0; inject = '0;
    for (int i = 0; i < N; i++) do_read(i, 0, "R7 meta cleared");
    do_read(1, 3, "R7 flag cleared");
    step('0, ci ^ 6'b000010, ci);
    step('0, ci ^ 6'b000010, ci ^ 6'b000010);
    do_read(1, 1, "R7 history kept across clear");

    // bit independence: R9
    for (int k = 0; k < 5; k++) step(6'b010000, ci, ci);
    step('0, ci, ci);
    do_read(4, 0, "R9 bit4 meta");
    do_read(3, 0, "R9 bit3 untouched");

    // back-pressure: R10
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_idx = 3'd4; req_code = 2'd0;
    @(negedge clk);
    req_idx = 3'd3;
    held = rsp_data;
    check("R10 first response data", int'(held), 5);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 req_ready low while stalled", int'(req_ready), 0);
      check("R10 rsp_valid held", int'(rsp_valid), 1);
      check("R10 rsp_data stable", int'(rsp_data), int'(held));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 next request served", int'(rsp_data), 0);

    // saturation on bit 0: R6
    for (int k = 0; k < 65540; k++) step(6'b000001, ci, ci);
    step('0, ci, ci);
    do_read(0, 0, "R6 saturated");
    do_read(5, 0, "R9 bit5 after saturation run");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule